// File: doc/BRIEF.md
# Receive Frame Buffer Segmenter

This block sits behind an HDLC deframer. It takes a stream of received octets, one per handshake, together with an end-of-frame marker and a count of residual bits for a final octet that is not whole. It stores the stream in a ring of fixed-size buffers in memory, using a plain word-write port. Octets are packed four to a 32-bit word, least significant lane first. A partly filled word is written with zero padding when the frame ends.

In HDLC mode a buffer is closed as soon as it holds the programmed maximum number of data bytes, and the frame carries on in the next slot of the ring. Each slot is four bytes longer than that maximum. The spare word is used only when a frame ends off an octet boundary. In that case the buffer that ends the frame gets one extra status word, placed directly after its data, which carries the residual bit count. In transparent mode the length limit is ignored and a buffer closes only at end of frame.

Every closed buffer is announced on a valid/ready report channel with its ring index, data byte count, end-of-frame flag and non-octet flag. A slot stays consumed until the host hands it back. When no slot is free, the octet input is held off.

Top module: `rx_buf_seg`

## Requirements
- R1: Byte k of a buffer (counting from 0) is placed in lane k mod 4 of the 32-bit word at byte address slot_base + 4*floor(k/4). Lane j occupies data bits 8j+7:8j. Each word is written once, so a frame of L bytes with no residual bits produces exactly ceil(L/4) memory writes.
- R2: With cfg_hdlc=1, a buffer that reaches cfg_max_len bytes before the frame ends is reported with count cfg_max_len, rep_eof=0 and rep_nonoct=0. The following byte of the frame becomes byte 0 of the next slot.
- R3: Slot i begins at BASE_ADDR + i*(cfg_max_len+4). Slots are used in order 0,1,…,N_SLOTS-1 and then wrap to 0. rep_idx carries the slot index of the buffer being reported.
- R4: At end of frame the final word is written with zeroes in the unused upper lanes. The buffer is reported with rep_eof=1 and a count of the data bytes only.
- R5: When in_resid is non-zero on the end-of-frame byte, the cycle after the last data word writes one status word at slot_base + 4*ceil(count/4). That word holds in_resid in bits 2:0 and zero elsewhere, and the report has rep_nonoct=1. When in_resid is zero, no word is written at that address and rep_nonoct=0.
- R6: A frame whose end coincides with the buffer filling to cfg_max_len produces a single report with rep_eof=1 and count cfg_max_len. Any status word goes to the reserved word at slot_base + cfg_max_len.
- R7: With cfg_hdlc=0, the length limit has no effect. A frame of L bytes produces one buffer with count L, rep_eof=1, and data words packed as in R1.
- R8: N_SLOTS slots are free after reset. Each report handshake consumes one and each buf_release pulse returns one. in_ready is low while no slot is free.
- R9: While rep_valid is high and rep_ready is low, all report fields hold their values and in_ready stays low.
- R10: After reset rep_valid=0, mem_we=0 with no input, in_ready=1, and the first buffer uses slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hdlc | input | 1 | 1: length-based segmentation, 0: transparent |
| cfg_max_len | input | LEN_W | Data bytes per buffer, multiple of 4, non-zero |
| in_valid | input | 1 | Octet present |
| in_ready | output | 1 | Octet accepted when high with in_valid |
| in_data | input | 8 | Received octet |
| in_eof | input | 1 | Octet is the last of its frame |
| in_resid | input | 3 | Residual bit count of a non-octet frame end, 0 if aligned |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Byte address of the word, 4-byte aligned |
| mem_wdata | output | 32 | Word data |
| rep_valid | output | 1 | Closed buffer report present |
| rep_ready | input | 1 | Report taken |
| rep_idx | output | IDX_W | Slot index of the closed buffer |
| rep_count | output | LEN_W | Data byte count |
| rep_eof | output | 1 | Buffer ends its frame |
| rep_nonoct | output | 1 | Status word was written after the data |
| buf_release | input | 1 | Host returns one slot |

## Verification
The collision of interest is a buffer filling up in the same cycle that its frame ends, with or without residual bits. Near that collision the length limit and the end-of-frame close compete, and the residual word has to fall in the reserved tail word. The bench sweeps every frame length from 1 to twice the buffer size plus five against three buffer sizes, so every phase of the final byte relative to both the word lane and the buffer boundary occurs. Each result is judged from the recorded memory image, from the list of reports, and from the exact number of writes.

// File: rtl/rx_buf_seg_pkg.sv
package rx_buf_seg_pkg;

   localparam int WORD_BYTES = 4;
   localparam int RESID_W    = 3;

   typedef enum logic [1:0] {
      ST_FILL = 2'd0,
      ST_STAT = 2'd1,
      ST_REP  = 2'd2
   } seg_state_e;

   function automatic logic [8*WORD_BYTES-1:0] resid_word(input logic [RESID_W-1:0] r);
      return {{(8*WORD_BYTES-RESID_W){1'b0}}, r};
   endfunction

endpackage

// File: rtl/rxs_packer.sv
module rxs_packer #(
   parameter  int LANES = 4,
   localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic               flush,
   input  logic [LW-1:0]      lane,
   input  logic [7:0]         din,
   output logic [8*LANES-1:0] word
);

   initial assert (LANES >= 2 && (LANES & (LANES - 1)) == 0)
      else $error("rxs_packer: LANES must be a power of two");

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      if (j < LANES - 1) begin : g_held
         logic [7:0] held;
         always_ff @(posedge clk) begin
            if (!rst_n)                        held <= '0;
            else if (take && flush)            held <= '0;
            else if (take && lane == LW'(j))   held <= din;
         end
         assign word[8*j +: 8] = (lane == LW'(j)) ? din :
                                 (LW'(j) < lane)  ? held : 8'h00;
      end else begin : g_top
         assign word[8*j +: 8] = (lane == LW'(j)) ? din : 8'h00;
      end
   end

endmodule

// File: rtl/rxs_ring.sv
module rxs_ring #(
   parameter  int              N_SLOTS   = 4,
   parameter  int              ADDR_W    = 16,
   parameter  int              LEN_W     = 8,
   parameter  logic [ADDR_W-1:0] BASE_ADDR = '0,
   localparam int              IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
   localparam int              FREE_W    = $clog2(N_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  max_len,
   input  logic              close,
   input  logic              release_one,
   output logic [IDX_W-1:0]  idx,
   output logic              have_free,
   output logic [ADDR_W-1:0] slot_base
);

   initial assert (N_SLOTS >= 1) else $error("rxs_ring: need at least one slot");

   logic [IDX_W-1:0]  idx_nxt;
   logic [FREE_W-1:0] free_cnt;

   if (N_SLOTS > 1 && (N_SLOTS & (N_SLOTS - 1)) == 0) begin : g_pow2
      assign idx_nxt = idx + 1'b1;
   end else begin : g_cmp
      assign idx_nxt = (idx == IDX_W'(N_SLOTS - 1)) ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx      <= '0;
         free_cnt <= FREE_W'(N_SLOTS);
      end else begin
         if (close) idx <= idx_nxt;
         free_cnt <= free_cnt + FREE_W'(release_one) - FREE_W'(close);
      end
   end

   assign have_free = (free_cnt != '0);
   assign slot_base = BASE_ADDR + ADDR_W'(idx) * (ADDR_W'(max_len) + ADDR_W'(4));

   // R8: free slots never exceed the ring size, never underflow on close
   a_r8_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= FREE_W'(N_SLOTS));
   a_r8_close_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
      close |-> (free_cnt != '0 || release_one));

endmodule

// File: rtl/rx_buf_seg.sv
module rx_buf_seg
   import rx_buf_seg_pkg::*;
#(
   parameter  int                ADDR_W    = 16,
   parameter  int                LEN_W     = 8,
   parameter  int                N_SLOTS   = 4,
   parameter  logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
   localparam int                IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
   localparam int                WORD_W    = 8 * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_hdlc,
   input  logic [LEN_W-1:0]  cfg_max_len,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_eof,
   input  logic [RESID_W-1:0] in_resid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              rep_valid,
   input  logic              rep_ready,
   output logic [IDX_W-1:0]  rep_idx,
   output logic [LEN_W-1:0]  rep_count,
   output logic              rep_eof,
   output logic              rep_nonoct,
   input  logic              buf_release
);

   localparam int LW = $clog2(WORD_BYTES);

   initial assert (ADDR_W >= LEN_W && LEN_W > LW)
      else $error("rx_buf_seg: address must be at least as wide as the length");

   seg_state_e         st;
   logic [LEN_W-1:0]   byte_cnt;
   logic [LEN_W-1:0]   cnt_nxt;
   logic               eof_q, nonoct_q;
   logic [RESID_W-1:0] resid_q;
   logic               accept, full, flush, closing;
   logic [LW-1:0]      lane;
   logic [WORD_W-1:0]  packed_word;
   logic [ADDR_W-1:0]  slot_base, data_off, stat_off;
   logic               have_free;

   assign in_ready = (st == ST_FILL) && have_free;
   assign accept   = in_valid && in_ready;
   assign lane     = byte_cnt[LW-1:0];
   assign cnt_nxt  = byte_cnt + 1'b1;
   assign full     = cfg_hdlc && (cnt_nxt == cfg_max_len);
   assign flush    = accept && ((lane == LW'(WORD_BYTES - 1)) || in_eof || full);
   assign closing  = rep_valid && rep_ready;

   rxs_packer #(.LANES(WORD_BYTES)) u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (accept),
      .flush (flush),
      .lane  (lane),
      .din   (in_data),
      .word  (packed_word)
   );

   rxs_ring #(
      .N_SLOTS   (N_SLOTS),
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .max_len     (cfg_max_len),
      .close       (closing),
      .release_one (buf_release),
      .idx         (rep_idx),
      .have_free   (have_free),
      .slot_base   (slot_base)
   );

   assign data_off = ADDR_W'({byte_cnt[LEN_W-1:LW], {LW{1'b0}}});
   assign stat_off = (ADDR_W'(byte_cnt) + ADDR_W'(WORD_BYTES - 1)) & ~ADDR_W'(WORD_BYTES - 1);

   assign mem_we    = flush || (st == ST_STAT);
   assign mem_addr  = slot_base + ((st == ST_STAT) ? stat_off : data_off);
   assign mem_wdata = (st == ST_STAT) ? resid_word(resid_q) : packed_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_FILL;
         byte_cnt <= '0;
         eof_q    <= 1'b0;
         nonoct_q <= 1'b0;
         resid_q  <= '0;
      end else begin
         unique case (st)
            ST_FILL: if (accept) begin
               byte_cnt <= cnt_nxt;
               if (in_eof || full) begin
                  eof_q    <= in_eof;
                  nonoct_q <= in_eof && (in_resid != '0);
                  resid_q  <= in_resid;
                  st       <= (in_eof && in_resid != '0) ? ST_STAT : ST_REP;
               end
            end
            ST_STAT: st <= ST_REP;
            ST_REP: if (rep_ready) begin
               st       <= ST_FILL;
               byte_cnt <= '0;
               eof_q    <= 1'b0;
               nonoct_q <= 1'b0;
            end
            default: st <= ST_FILL;
         endcase
      end
   end

   assign rep_valid  = (st == ST_REP);
   assign rep_count  = byte_cnt;
   assign rep_eof    = eof_q;
   assign rep_nonoct = nonoct_q;

   // R1: every write is a whole aligned word
   a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[LW-1:0] == '0));
   // R2: a segmented buffer never reports more than the limit, nor zero bytes
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_valid && cfg_hdlc) |-> (rep_count <= cfg_max_len && rep_count != '0));
   // R5: a status word is always followed by a non-octet report
   a_r5_stat_then_report: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STAT) |=> (rep_valid && rep_nonoct && rep_eof));
   // R6: writes stay inside the slot, the reserved tail word included
   a_r6_slot_room: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && cfg_hdlc) |-> ((mem_addr - slot_base) <= ADDR_W'(cfg_max_len)));
   // R8: no octet taken without a free slot
   a_r8_hold_without_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !have_free |-> !in_ready);
   // R9: a pending report holds still and blocks input
   a_r9_report_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_valid && !rep_ready) |=> (rep_valid && !in_ready && $stable(rep_count)
                                     && $stable(rep_idx) && $stable(rep_eof)
                                     && $stable(rep_nonoct)));

endmodule

// File: tb/rx_buf_seg_bench.sv
`timescale 1ns/1ps
module rx_buf_seg_bench;

   localparam int ADDR_W = 16;
   localparam int LEN_W  = 8;
   localparam int NS     = 4;
   localparam int BASE   = 'h0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_hdlc = 1'b1;
   logic [LEN_W-1:0] cfg_max_len = 8'd4;
   logic in_valid = 1'b0, in_ready, in_eof = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [2:0] in_resid = 3'd0;
   logic mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic rep_valid, rep_ready = 1'b1, rep_eof, rep_nonoct, buf_release;
   logic [1:0] rep_idx;
   logic [LEN_W-1:0] rep_count;

   always #10 clk = ~clk;

   rx_buf_seg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .N_SLOTS(NS), .BASE_ADDR(16'h0100)) u_rx_buf_seg (
      .clk(clk), .rst_n(rst_n), .cfg_hdlc(cfg_hdlc), .cfg_max_len(cfg_max_len),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eof(in_eof),
      .in_resid(in_resid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_idx(rep_idx),
      .rep_count(rep_count), .rep_eof(rep_eof), .rep_nonoct(rep_nonoct),
      .buf_release(buf_release));

   int errors = 0, checks = 0;
   bit done = 1'b0;
   logic [31:0] shadow [0:255];
   int n_wr = 0, rep_n = 0;
   int q_idx [0:63], q_cnt [0:63];
   bit q_eof [0:63], q_no [0:63];
   bit clr_req = 1'b0, auto_rel = 1'b1, man_rel = 1'b0;
   int exp_idx = 0, frame_no = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: samples at the falling edge, drives buf_release
   initial forever begin
      @(negedge clk);
      if (clr_req) begin
         for (int i = 0; i < 256; i++) shadow[i] = 32'hDEADBEEF;
         n_wr = 0; rep_n = 0;
      end else begin
         if (mem_we) begin shadow[mem_addr[9:2]] = mem_wdata; n_wr++; end
         if (rep_valid && rep_ready && rep_n < 64) begin
            q_idx[rep_n] = rep_idx; q_cnt[rep_n] = rep_count;
            q_eof[rep_n] = rep_eof; q_no[rep_n] = rep_nonoct; rep_n++;
         end
      end
      buf_release = (auto_rel && rep_valid && rep_ready) || man_rel;
   end

   function automatic logic [7:0] pat(input int f, input int i);
      return 8'((f * 37 + i * 5 + 1) & 255);
   endfunction

   task automatic clear_log();
      clr_req = 1'b1; @(negedge clk); #1 clr_req = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic send_byte(input logic [7:0] d, input logic e, input logic [2:0] r);
      in_valid = 1'b1; in_data = d; in_eof = e; in_resid = r;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0; in_eof = 1'b0; in_resid = 3'd0;
   endtask

   task automatic run_frame(input int len, input int r, input bit hdlc, input int m);
      int nb, off, c, base, nw, sloc;
      logic [31:0] ew;
      cfg_hdlc = hdlc; cfg_max_len = LEN_W'(m);
      clear_log();
      for (int i = 0; i < len; i++)
         send_byte(pat(frame_no, i), i == len - 1, (i == len - 1) ? 3'(r) : 3'd0);
      repeat (4) @(negedge clk);
      nb = hdlc ? (len + m - 1) / m : 1;
      chk(rep_n == nb, hdlc ? "R2 buffer count" : "R7 buffer count", rep_n, nb);
      off = 0;
      for (int b = 0; b < nb && b < rep_n; b++) begin
         bit last = (b == nb - 1);
         c = hdlc ? ((len - off < m) ? len - off : m) : len;
         base = BASE + exp_idx * (m + 4);
         chk(q_idx[b] == exp_idx, "R3 slot index", q_idx[b], exp_idx);
         chk(q_cnt[b] == c, last ? ((c == m && hdlc) ? "R6 count" : "R4 count") : "R2 count", q_cnt[b], c);
         chk(q_eof[b] == last, last ? "R4 eof flag" : "R2 eof flag", q_eof[b], last);
         chk(q_no[b] == (last && r != 0), "R5 nonoct flag", q_no[b], last && r != 0);
         nw = (c + 3) / 4;
         for (int w = 0; w < nw; w++) begin
            ew = '0;
            for (int j = 0; j < 4; j++)
               if (4 * w + j < c) ew[8*j +: 8] = pat(frame_no, off + 4 * w + j);
            chk(shadow[((base + 4 * w) >> 2) & 255] == ew, hdlc ? "R1 data word" : "R7 data word",
                shadow[((base + 4 * w) >> 2) & 255], ew);
         end
         if (last) begin
            sloc = ((base + 4 * nw) >> 2) & 255;
            if (r != 0)
               chk(shadow[sloc] == 32'(r), (c == m && hdlc) ? "R6 status word" : "R5 status word", shadow[sloc], r);
            else
               chk(shadow[sloc] == 32'hDEADBEEF, "R5 no status word", shadow[sloc], 32'hDEADBEEF);
         end
         off += c;
         exp_idx = (exp_idx + 1) % NS;
      end
      chk(n_wr == (len + 3) / 4 + (r != 0 ? 1 : 0), "R1 write count", n_wr, (len + 3) / 4 + (r != 0 ? 1 : 0));
      frame_no++;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(rep_valid == 1'b0, "R10 rep_valid", rep_valid, 0);
      chk(mem_we == 1'b0, "R10 mem_we", mem_we, 0);
      chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
      @(posedge clk); #1;

      for (int mi = 1; mi <= 3; mi++)
         for (int len = 1; len <= 8 * mi + 5; len++)
            for (int rr = 0; rr < 2; rr++)
               run_frame(len, rr ? 3 : 0, 1'b1, 4 * mi);

      for (int len = 1; len <= 20; len++)
         for (int rr = 0; rr < 2; rr++)
            run_frame(len, rr ? 5 : 0, 1'b0, 4);

      // R8: exhaust the ring, then hand one slot back
      cfg_hdlc = 1'b1; cfg_max_len = 8'd4;
      auto_rel = 1'b0;
      for (int k = 0; k < NS; k++) begin
         send_byte(8'h11, 1'b1, 3'd0);
         repeat (3) @(posedge clk); #1;
      end
      @(negedge clk);
      chk(in_ready == 1'b0, "R8 ring exhausted", in_ready, 0);
      @(posedge clk); #1 man_rel = 1'b1;
      @(posedge clk); #1 man_rel = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R8 slot returned", in_ready, 1);
      for (int k = 1; k < NS; k++) begin
         @(posedge clk); #1 man_rel = 1'b1;
         @(posedge clk); #1 man_rel = 1'b0;
      end
      auto_rel = 1'b1;
      @(posedge clk); #1;

      // R9: report held while rep_ready is low
      rep_ready = 1'b0;
      send_byte(8'h5A, 1'b1, 3'd0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(rep_valid == 1'b1, "R9 rep_valid held", rep_valid, 1);
         chk(rep_count == 8'd1, "R9 count held", rep_count, 1);
         chk(rep_idx == 2'(exp_idx), "R9 index held", rep_idx, exp_idx);
         chk(in_ready == 1'b0, "R9 input blocked", in_ready, 0);
      end
      @(posedge clk); #1 rep_ready = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      chk(rep_valid == 1'b0, "R9 report taken", rep_valid, 0);
      exp_idx = (exp_idx + 1) % NS;
      run_frame(6, 3, 1'b1, 4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule